// File: doc/BRIEF.md
# GPIO and Control Register Bank

This block is a small register bank on a simple memory-mapped bus. The bus has 32-bit addresses and 32-bit write data, but only the low 16 data bits are kept. The bank holds six plain storage registers: an operating mode, a clock divider, a clock control word and three interrupt words (request, mask and status). The interrupt words are stored and read back but drive nothing. It also holds a power word with a forcing rule, and a fixed status word.

Alongside the registers sits a 16-line general-purpose I/O unit. It has a direction register and a level register. An output line is driven high only when both its level bit and its direction bit are 1. The effective outputs are held in a register that is recomputed only on a direction write or a level write. Any line whose effective output changes on a recompute gives a one-cycle strobe.

Each of the 16 input lines passes through a two-flop synchronizer. When a synchronized input changes, it copies its new value into its own bit of the level register. This copy does not recompute the outputs.

Top module: `gpio_ctrl_regs`

## Requirements
- R1: Only address bits [5:0] are decoded, so any address whose low six bits match an offset reaches that register. The offsets are:
  - mode at 0x00
  - clock divider at 0x04
  - status at 0x08
  - power at 0x0C
  - clock control at 0x10
  - interrupt request at 0x14
  - interrupt mask at 0x18
  - interrupt status at 0x1C
  - direction at 0x20
  - level at 0x24 and at 0x28
- R2: Write data is cut to bits [15:0]. The mode, clock divider, clock control and the three interrupt registers read back exactly what was last written to them.
- R3: A power write stores the value. If bit 7 of the written value is 1, bits 15 and 6 are also set (OR with 0x8040).
- R4: The status register at 0x08 always reads 0x0002. Writes to it are ignored.
- R5: Reads of an undecoded offset (above 0x28 or not a multiple of 4) return 0. Writes to an undecoded offset change no register.
- R6: A write to 0x24 or 0x28 stores (written value AND current direction) as the level. Reads of 0x24 and 0x28 both return the level register. A read of 0x20 returns the direction register.
- R7: After each direction or level write, `gpio_out` becomes level AND direction, taking the new values. It changes at no other time.
- R8: `gpio_chg` is high for exactly one cycle, in the cycle `gpio_out` takes its new value, and only on the lines whose effective output changed. A recompute that changes nothing gives no strobe.
- R9: When a synchronized input line changes value, it writes that value into its level bit. This is visible on a level read no later than four clocks after the input change. `gpio_out` and `gpio_chg` do not react to it.
- R10: If a synchronized input change and a bus level write reach the level register on the same clock edge, the bus write wins and the input change is dropped.
- R11: After reset these all read 0: every register except status, `gpio_out` and `gpio_chg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address; only bits [5:0] are decoded |
| bus_wdata | input | 32 | Write data; bits [15:0] are kept |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| gpio_in | input | 16 | Asynchronous input lines |
| gpio_out | output | 16 | Effective output levels |
| gpio_chg | output | 16 | One-cycle change strobe per output line |

## Verification
The bench aims at the direction gating.

- A level write made while some direction bits are 0 must store only the enabled bits. A design that stores the raw value shows extra ones on readback.
- A direction change alone must move `gpio_out` and strobe only the affected lines. A design that recomputes from the old direction shows a stale output or a wrong strobe mask.
- Input edges must update the level without moving the outputs. A design that recomputes on input sees `gpio_out` follow the pins.
- A bus write and an input change are timed to land on the same edge. A design with the wrong priority keeps the input bit.
- Address aliasing in the high bits is checked, and so are the power forcing bits. A decoder that reads too many bits, or a missing OR-mask, shows up as wrong readback.

// File: rtl/gcr_pkg.sv
package gcr_pkg;

  localparam int DEC_W = 6;

  localparam int PWR_TRIG_BIT = 7;
  localparam logic [15:0] PWR_FORCE = 16'h8040;

  typedef enum logic [3:0] {
    ID_MODE,
    ID_CDIV,
    ID_STAT,
    ID_PWR,
    ID_CCTL,
    ID_IREQ,
    ID_IMSK,
    ID_ISTS,
    ID_GDIR,
    ID_GLVL,
    ID_NONE
  } reg_id_e;

endpackage

// File: rtl/gcr_decode.sv
module gcr_decode
  import gcr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_id_e           id
);

  logic [DEC_W-1:0] off;

  assign off = addr[DEC_W-1:0];

  // R1: only the low bits take part in the decode
  always_comb begin
    unique case (off)
      6'h00:        id = ID_MODE;
      6'h04:        id = ID_CDIV;
      6'h08:        id = ID_STAT;
      6'h0C:        id = ID_PWR;
      6'h10:        id = ID_CCTL;
      6'h14:        id = ID_IREQ;
      6'h18:        id = ID_IMSK;
      6'h1C:        id = ID_ISTS;
      6'h20:        id = ID_GDIR;
      6'h24, 6'h28: id = ID_GLVL;
      default:      id = ID_NONE;
    endcase
  end

endmodule

// File: rtl/gcr_ctrl_bank.sv
module gcr_ctrl_bank
  import gcr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_id_e       id,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mode_q,
  output logic [DW-1:0] cdiv_q,
  output logic [DW-1:0] pwr_q,
  output logic [DW-1:0] cctl_q,
  output logic [DW-1:0] ireq_q,
  output logic [DW-1:0] imsk_q,
  output logic [DW-1:0] ists_q
);

  logic [DW-1:0] pwr_d;
  logic          mode_en, cdiv_en, pwr_en, cctl_en, ireq_en, imsk_en, ists_en;

  always_comb begin
    mode_en = wr_en && (id == ID_MODE);
    cdiv_en = wr_en && (id == ID_CDIV);
    pwr_en  = wr_en && (id == ID_PWR);
    cctl_en = wr_en && (id == ID_CCTL);
    ireq_en = wr_en && (id == ID_IREQ);
    imsk_en = wr_en && (id == ID_IMSK);
    ists_en = wr_en && (id == ID_ISTS);
  end

  // R3: bit 7 forces the extra power bits
  always_comb begin
    pwr_d = wdata;
    if (wdata[PWR_TRIG_BIT]) pwr_d = wdata | PWR_FORCE[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      cdiv_q <= '0;
      pwr_q  <= '0;
      cctl_q <= '0;
      ireq_q <= '0;
      imsk_q <= '0;
      ists_q <= '0;
    end else begin
      if (mode_en) mode_q <= wdata;
      if (cdiv_en) cdiv_q <= wdata;
      if (pwr_en)  pwr_q  <= pwr_d;
      if (cctl_en) cctl_q <= wdata;
      if (ireq_en) ireq_q <= wdata;
      if (imsk_en) imsk_q <= wdata;
      if (ists_en) ists_q <= wdata;
    end
  end

endmodule

// File: rtl/gcr_gpio.sv
module gcr_gpio #(
  parameter int N    = 16,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_we,
  input  logic         lvl_we,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] pin_in,
  output logic [N-1:0] dir_q,
  output logic [N-1:0] lvl_q,
  output logic [N-1:0] out_q,
  output logic [N-1:0] chg_q
);

  logic [N-1:0] sync_q [SYNC];
  logic [N-1:0] seen_q;
  logic [N-1:0] pin_s;
  logic [N-1:0] evt;
  logic [N-1:0] dir_d, lvl_d, out_d, chg_d;
  logic         recompute;

  assign pin_s = sync_q[SYNC-1];
  assign evt   = pin_s ^ seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '0;
      seen_q <= '0;
    end else begin
      sync_q[0] <= pin_in;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
      seen_q <= pin_s;
    end
  end

  // R9: an input edge copies its value into the level bit.
  // R10: a bus write replaces the input update.
  logic [N-1:0] lvl_pin;
  for (genvar b = 0; b < N; b++) begin : g_line
    assign lvl_pin[b] = evt[b] ? pin_s[b] : lvl_q[b];
  end

  always_comb begin
    dir_d     = dir_we ? wdata : dir_q;
    lvl_d     = lvl_we ? (wdata & dir_q) : lvl_pin;
    recompute = dir_we | lvl_we;
    out_d     = recompute ? (lvl_d & dir_d) : out_q;
    chg_d     = out_d ^ out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      lvl_q <= '0;
      out_q <= '0;
      chg_q <= '0;
    end else begin
      if (dir_we) dir_q <= dir_d;
      lvl_q <= lvl_d;
      if (recompute) out_q <= out_d;
      chg_q <= chg_d;
    end
  end

endmodule

// File: rtl/gpio_ctrl_regs.sv
module gpio_ctrl_regs
  import gcr_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          BUS_W      = 32,
  parameter int          DW         = 16,
  parameter int          GPIO_N     = 16,
  parameter int          SYNC       = 2,
  parameter logic [15:0] STATUS_RST = 16'h0002
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [GPIO_N-1:0] gpio_in,
  output logic [GPIO_N-1:0] gpio_out,
  output logic [GPIO_N-1:0] gpio_chg
);

  reg_id_e           id;
  logic              wr_en;
  logic [DW-1:0]     wdat;
  logic [DW-1:0]     mode_q, cdiv_q, pwr_q, cctl_q, ireq_q, imsk_q, ists_q;
  logic [GPIO_N-1:0] dir_q, lvl_q;

  assign wr_en = bus_sel && bus_wr;
  assign wdat  = bus_wdata[DW-1:0];   // R2: truncate

  gcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .id   (id)
  );

  gcr_ctrl_bank #(.DW(DW)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .id     (id),
    .wdata  (wdat),
    .mode_q (mode_q),
    .cdiv_q (cdiv_q),
    .pwr_q  (pwr_q),
    .cctl_q (cctl_q),
    .ireq_q (ireq_q),
    .imsk_q (imsk_q),
    .ists_q (ists_q)
  );

  gcr_gpio #(.N(GPIO_N), .SYNC(SYNC)) u_gpio (
    .clk    (clk),
    .rst_n  (rst_n),
    .dir_we (wr_en && (id == ID_GDIR)),
    .lvl_we (wr_en && (id == ID_GLVL)),
    .wdata  (wdat[GPIO_N-1:0]),
    .pin_in (gpio_in),
    .dir_q  (dir_q),
    .lvl_q  (lvl_q),
    .out_q  (gpio_out),
    .chg_q  (gpio_chg)
  );

  // R4/R5: fixed status, zero for undecoded offsets
  always_comb begin
    unique case (id)
      ID_MODE: bus_rdata = mode_q;
      ID_CDIV: bus_rdata = cdiv_q;
      ID_STAT: bus_rdata = STATUS_RST[DW-1:0];
      ID_PWR:  bus_rdata = pwr_q;
      ID_CCTL: bus_rdata = cctl_q;
      ID_IREQ: bus_rdata = ireq_q;
      ID_IMSK: bus_rdata = imsk_q;
      ID_ISTS: bus_rdata = ists_q;
      ID_GDIR: bus_rdata = DW'(dir_q);
      ID_GLVL: bus_rdata = DW'(lvl_q);
      default: bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gcr_chk.sv
module gcr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [31:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic [15:0] gpio_out,
  input logic [15:0] gpio_chg,
  input logic [15:0] dir_q,
  input logic [15:0] lvl_q,
  input logic [15:0] pwr_q
);

  logic gpio_wr;
  logic lvl_wr;
  assign gpio_wr = bus_sel && bus_wr &&
                   (bus_addr[5:0] == 6'h20 || bus_addr[5:0] == 6'h24 || bus_addr[5:0] == 6'h28);
  assign lvl_wr  = bus_sel && bus_wr && (bus_addr[5:0] == 6'h24 || bus_addr[5:0] == 6'h28);

  p_power_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[5:0] == 6'h0C && bus_wdata[7]) |=> (pwr_q[15] && pwr_q[6]));

  p_status_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:0] == 6'h08) |-> (bus_rdata == 16'h0002));

  p_undecoded_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[5:0] > 6'h28 || bus_addr[1:0] != 2'b00) |-> (bus_rdata == 16'h0000));

  p_level_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_wr |=> (lvl_q == ($past(bus_wdata[15:0]) & $past(dir_q))));

  p_out_within_dir_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((gpio_out & ~dir_q) == 16'h0000));

  p_out_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gpio_wr |=> $stable(gpio_out));

  p_strobe_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (gpio_chg == (gpio_out ^ $past(gpio_out))));

endmodule

bind gpio_ctrl_regs gcr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .gpio_out  (gpio_out),
  .gpio_chg  (gpio_chg),
  .dir_q     (dir_q),
  .lvl_q     (lvl_q),
  .pwr_q     (pwr_q)
);

// File: tb/test_gpio_ctrl_regs.sv
`timescale 1ns/1ps
module test_gpio_ctrl_regs;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [31:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic [15:0] gpio_in;
  logic [15:0] gpio_out;
  logic [15:0] gpio_chg;

  int n_chk;
  int n_bad;
  logic [15:0] wr_out;
  logic [15:0] wr_chg;

  gpio_ctrl_regs i_gpio_ctrl_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .gpio_in   (gpio_in),
    .gpio_out  (gpio_out),
    .gpio_chg  (gpio_chg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on a falling edge, captured on the next rising edge, results sampled on the falling edge after
  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    wr_out = gpio_out;
    wr_chg = gpio_chg;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [31:0] a, input logic [15:0] exp);
    logic [15:0] d;
    bus_read(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    for (int k = 0; k <= 10; k++) begin
      if (k == 2) read_check("R4 status reset", 32'h08, 16'h0002);
      else        read_check("R11 reset zero", 32'(k * 4), 16'h0000);
    end
    check("R11 out reset", gpio_out, 16'h0000);
    check("R11 chg reset", gpio_chg, 16'h0000);
  endtask

  task automatic t_plain;
    bus_write(32'h00, 32'hABCD_1234);
    bus_write(32'h10, 32'h0000_0F0F);
    bus_write(32'h14, 32'h5555_AAAA);
    bus_write(32'h18, 32'h0000_00FF);
    bus_write(32'h1C, 32'hFFFF_8001);
    read_check("R2 mode", 32'h00, 16'h1234);
    read_check("R2 cctl", 32'h10, 16'h0F0F);
    read_check("R2 ireq", 32'h14, 16'hAAAA);
    read_check("R2 imsk", 32'h18, 16'h00FF);
    read_check("R2 ists", 32'h1C, 16'h8001);
  endtask

  task automatic t_alias;
    bus_write(32'hFFFF_FFC4, 32'h0000_55AA);
    read_check("R1 alias write", 32'h04, 16'h55AA);
    read_check("R1 alias read", 32'h1000_0044, 16'h55AA);
    read_check("R1 mode untouched", 32'h40, 16'h1234);
  endtask

  task automatic t_power;
    bus_write(32'h0C, 32'h0000_0001);
    read_check("R3 no force", 32'h0C, 16'h0001);
    bus_write(32'h0C, 32'h0000_0080);
    read_check("R3 force", 32'h0C, 16'h80C0);
    bus_write(32'h0C, 32'h0001_0180);
    read_check("R3 force keep", 32'h0C, 16'h81C0);
  endtask

  task automatic t_status;
    bus_write(32'h08, 32'h0000_FFFF);
    read_check("R4 status write ignored", 32'h08, 16'h0002);
  endtask

  task automatic t_undecoded;
    bus_write(32'h2C, 32'h0000_FFFF);
    bus_write(32'h3C, 32'h0000_FFFF);
    bus_write(32'h02, 32'h0000_FFFF);
    bus_write(32'h21, 32'h0000_FFFF);
    read_check("R5 read 0x2C", 32'h2C, 16'h0000);
    read_check("R5 read misaligned", 32'h02, 16'h0000);
    read_check("R5 mode kept", 32'h00, 16'h1234);
    read_check("R5 dir kept", 32'h20, 16'h0000);
    check("R5 out kept", gpio_out, 16'h0000);
  endtask

  task automatic t_gpio;
    bus_write(32'h20, 32'h0000_00FF);
    check("R7 dir only out", wr_out, 16'h0000);
    check("R8 no strobe", wr_chg, 16'h0000);
    bus_write(32'h24, 32'h0000_FFFF);
    check("R7 out after level", wr_out, 16'h00FF);
    check("R8 strobe level", wr_chg, 16'h00FF);
    @(negedge clk);
    check("R8 strobe one cycle", gpio_chg, 16'h0000);
    read_check("R6 level masked 0x24", 32'h24, 16'h00FF);
    read_check("R6 level masked 0x28", 32'h28, 16'h00FF);
    bus_write(32'h20, 32'h0000_0F0F);
    check("R7 out after dir", wr_out, 16'h000F);
    check("R8 strobe dir", wr_chg, 16'h00F0);
    read_check("R6 dir read", 32'h20, 16'h0F0F);
    read_check("R6 level kept", 32'h24, 16'h00FF);
    bus_write(32'h28, 32'h0000_FFFF);
    check("R7 out via 0x28", wr_out, 16'h0F0F);
    check("R8 strobe 0x28", wr_chg, 16'h0F00);
    read_check("R6 level via 0x28", 32'h24, 16'h0F0F);
    bus_write(32'h24, 32'h0000_0F0F);
    check("R8 same value no strobe", wr_chg, 16'h0000);
  endtask

  task automatic t_input;
    int strobes;
    int moves;
    strobes = 0;
    moves = 0;
    @(negedge clk);
    gpio_in = 16'hF000;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (gpio_chg != 16'h0000) strobes++;
      if (gpio_out != 16'h0F0F) moves++;
    end
    read_check("R9 input sets", 32'h24, 16'hFF0F);
    gpio_in = 16'h0000;
    repeat (5) @(negedge clk);
    read_check("R9 input clears", 32'h28, 16'h0F0F);
    gpio_in = 16'h0001;
    repeat (5) @(negedge clk);
    gpio_in = 16'h0000;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (gpio_chg != 16'h0000) strobes++;
      if (gpio_out != 16'h0F0F) moves++;
    end
    read_check("R9 bit0 cleared", 32'h24, 16'h0F0E);
    check("R9 no strobe from input", 16'(strobes), 16'h0000);
    check("R9 out not moved", 16'(moves), 16'h0000);
    bus_write(32'h20, 32'h0000_0F0F);
    check("R7 recompute after input", wr_out, 16'h0F0E);
    check("R8 strobe after input", wr_chg, 16'h0001);
  endtask

  task automatic t_collide;
    // input change on a falling edge is seen by the level register on the third rising edge
    @(negedge clk);
    gpio_in = 16'h0002;
    @(negedge clk);
    bus_write(32'h24, 32'h0000_0000);
    repeat (5) @(negedge clk);
    read_check("R10 bus write wins", 32'h24, 16'h0000);
    check("R10 out", gpio_out, 16'h0000);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    bus_sel = 1'b0;
    bus_wr = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    gpio_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_plain();
    t_alias();
    t_power();
    t_status();
    t_undecoded();
    t_gpio();
    t_input();
    t_collide();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule